// File: doc/BRIEF.md
# Debug Port Mode Select Detector

This block watches the shared mode/data line of a combined serial-wire and JTAG debug port on the target side. An upstream synchroniser supplies a one-clock strobe for each rising edge of the debug clock, together with the line value sampled on that edge. The detector tracks runs of consecutive high bits. It recognises a line reset and then decodes the 16-bit select word that may follow, to decide whether the port currently operates as JTAG or as serial-wire debug.

The current mode is a registered output, and the port leaves power-on reset in JTAG mode. The detector also produces a one-clock line-reset pulse and a one-clock mode-change pulse, and it keeps a level that reports whether the JTAG TAP is being held in Test-Logic-Reset. It accepts both the current pair of select words and an older, deprecated pair. A parameter decides whether the older pair is recognised.

Top module: `dbg_port_mode_detect`

## Requirements
- R1: While the synchronous reset `rst` is high, and at the first sample after it, `mode_swd` is 0 (JTAG), `tap_tlr` is 1, and both pulse outputs are 0.
- R2: `line_rst_pulse` is high for exactly one clock after the strobe edge that samples the 51st consecutive high bit. The run counter saturates, so a longer run gives no second pulse, and a run of 50 gives no pulse.
- R3: Bits are assembled least significant first. If the 16 bits that start at the first low bit after a run of at least 51 high bits equal 16'hE79E, `mode_swd` becomes 1 at the edge that samples the 16th bit.
- R4: Under the same framing, the word 16'hE73C selects JTAG (`mode_swd` = 0).
- R5: With legacy acceptance enabled (the default), 16'hEDB6 selects serial-wire mode and 16'hDEAE selects JTAG.
- R6: A select word that is not preceded by a qualifying run of at least 51 high bits has no effect on the mode.
- R7: A word that matches no select code is discarded. A correct word that then follows without a new line reset has no effect.
- R8: A valid word that names the mode already active leaves the mode unchanged and gives no mode-change pulse.
- R9: `mode_chg_pulse` is high for exactly one clock, in the cycle in which `mode_swd` shows its new value.
- R10: `tap_tlr` is set by a JTAG select word, and in JTAG mode by any run of at least 5 high bits. In JTAG mode a low bit clears it. In serial-wire mode it is 0.
- R11: When `bit_vld` is low, `bit_in` is ignored: no output changes.
- R12: If reset is asserted in the same cycle as the final bit of a valid select word, reset wins: the mode stays JTAG and no mode-change pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bit_vld | input | 1 | One-clock strobe marking a sampled rising debug-clock edge |
| bit_in | input | 1 | Mode/data line value sampled on that edge |
| mode_swd | output | 1 | Current mode: 1 serial-wire, 0 JTAG |
| line_rst_pulse | output | 1 | One-clock pulse on a qualifying line reset |
| mode_chg_pulse | output | 1 | One-clock pulse when the mode flips |
| tap_tlr | output | 1 | TAP held in Test-Logic-Reset (JTAG mode only) |

## Verification
Two events can coincide in one cycle: the completion of a select word and a synchronous reset. The bench feeds a qualifying high run and the first 15 bits of the serial-wire word. It then raises `rst` in the very cycle that the 16th bit is strobed in, and requires JTAG mode with no change pulse afterwards. The bench also judges a second coincidence: the line-reset pulse together with the TAP-reset level. A long run of ones in JTAG mode must raise `tap_tlr` and still produce exactly one line-reset pulse. Every strobed bit is compared against a bench model built on a bit-history window. Each strobed bit is followed by an idle cycle with random line values, which checks that idle cycles have no effect.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

  localparam int CODE_W = 16;

  typedef enum logic {
    PM_JTAG = 1'b0,
    PM_SWD  = 1'b1
  } port_mode_e;

  // select words, LSB is the first bit on the line
  localparam logic [CODE_W-1:0] SEL_SWD_CUR  = 16'hE79E;
  localparam logic [CODE_W-1:0] SEL_JTAG_CUR = 16'hE73C;
  localparam logic [CODE_W-1:0] SEL_SWD_OLD  = 16'hEDB6;
  localparam logic [CODE_W-1:0] SEL_JTAG_OLD = 16'hDEAE;

endpackage

// File: rtl/ones_run_tracker.sv
module ones_run_tracker #(
  parameter int RST_MIN = 51,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [CNT_W-1:0] run_cnt,
  output logic             run_qual,
  output logic             lr_now,
  output logic             lr_pulse
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RST_MIN);
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(RST_MIN - 1);

  // current strobe completes a qualifying run
  assign lr_now   = bit_vld && bit_in && (run_cnt == CNT_PRE);
  assign run_qual = (run_cnt == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      lr_pulse <= 1'b0;
    end else begin
      lr_pulse <= lr_now;
      if (bit_vld) begin
        if (!bit_in)
          run_cnt <= '0;
        else if (run_cnt != CNT_FULL)
          run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R2: counter saturates at the threshold
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= CNT_FULL);

  // R2: pulse lasts a single clock
  p_lr_once_r2: assert property (@(posedge clk) disable iff (rst)
    lr_pulse |=> !lr_pulse);

  // R2: pulse only after the run reached the threshold
  p_lr_after_run_r2: assert property (@(posedge clk) disable iff (rst)
    lr_pulse |-> (run_cnt == CNT_FULL));

endmodule

// File: rtl/sel_code_matcher.sv
module sel_code_matcher
  import dbg_mode_pkg::*;
#(
  parameter bit ACCEPT_LEGACY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic run_qual,
  input  logic lr_now,
  output logic hit_swd,
  output logic hit_jtag
);

  localparam int IDX_W = $clog2(CODE_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CODE_W - 1);

  logic              capturing;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] shreg;
  logic [CODE_W-1:0] word_now;
  logic              word_done;
  logic              is_swd;
  logic              is_jtag;

  // new bit enters at the top; after CODE_W shifts the first bit is the LSB
  assign word_now  = {bit_in, shreg[CODE_W-1:1]};
  assign word_done = bit_vld && capturing && (idx == IDX_LAST) && !lr_now;

  generate
    if (ACCEPT_LEGACY) begin : g_legacy
      assign is_swd  = (word_now == SEL_SWD_CUR)  || (word_now == SEL_SWD_OLD);
      assign is_jtag = (word_now == SEL_JTAG_CUR) || (word_now == SEL_JTAG_OLD);
    end else begin : g_current
      assign is_swd  = (word_now == SEL_SWD_CUR);
      assign is_jtag = (word_now == SEL_JTAG_CUR);
    end
  endgenerate

  assign hit_swd  = word_done && is_swd;
  assign hit_jtag = word_done && is_jtag;

  always_ff @(posedge clk) begin
    if (rst) begin
      capturing <= 1'b0;
      idx       <= '0;
      shreg     <= '0;
    end else if (bit_vld) begin
      if (lr_now) begin
        capturing <= 1'b0;
      end else if (capturing) begin
        shreg <= word_now;
        if (idx == IDX_LAST)
          capturing <= 1'b0;
        else
          idx <= idx + 1'b1;
      end else if (run_qual && !bit_in) begin
        capturing <= 1'b1;
        idx       <= IDX_W'(1);
        shreg     <= word_now;
      end
    end
  end

  // R3: the two selections never coincide
  p_hit_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(hit_swd && hit_jtag));

  // R6: capture only opens right after a qualifying run
  p_capture_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(capturing) |-> $past(run_qual));

  // R11: idle cycles leave the assembled word alone
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(shreg) && $stable(capturing));

endmodule

// File: rtl/port_mode_ctrl.sv
module port_mode_ctrl
  import dbg_mode_pkg::*;
#(
  parameter int TLR_ONES = 5,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] run_cnt,
  input  logic             hit_swd,
  input  logic             hit_jtag,
  output port_mode_e       mode,
  output logic             mode_chg,
  output logic             tap_tlr
);

  localparam logic [CNT_W-1:0] TLR_PRE = CNT_W'(TLR_ONES - 1);

  logic ones_reach;
  assign ones_reach = bit_in && (run_cnt >= TLR_PRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= PM_JTAG;
      mode_chg <= 1'b0;
      tap_tlr  <= 1'b1;
    end else begin
      mode_chg <= 1'b0;
      if (hit_swd && mode == PM_JTAG) begin
        mode     <= PM_SWD;
        mode_chg <= 1'b1;
      end else if (hit_jtag && mode == PM_SWD) begin
        mode     <= PM_JTAG;
        mode_chg <= 1'b1;
      end

      if (hit_jtag)
        tap_tlr <= 1'b1;
      else if (hit_swd)
        tap_tlr <= 1'b0;
      else if (bit_vld && mode == PM_JTAG) begin
        if (!bit_in)
          tap_tlr <= 1'b0;
        else if (ones_reach)
          tap_tlr <= 1'b1;
      end
    end
  end

  // R9: change pulse is one clock wide
  p_chg_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !mode_chg);

  // R9: pulse marks a real flip
  p_chg_flip_r9: assert property (@(posedge clk) disable iff (rst)
    mode_chg |-> (mode != $past(mode)));

  // R8: no flip without a pulse
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !mode_chg |-> $stable(mode));

  // R10: TAP reset level is inactive in serial-wire mode
  p_swd_no_tlr_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_SWD) |-> !tap_tlr);

endmodule

// File: rtl/dbg_port_mode_detect.sv
module dbg_port_mode_detect
  import dbg_mode_pkg::*;
#(
  parameter int RST_MIN       = 51,
  parameter int TLR_ONES      = 5,
  parameter bit ACCEPT_LEGACY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic mode_swd,
  output logic line_rst_pulse,
  output logic mode_chg_pulse,
  output logic tap_tlr
);

  localparam int CNT_W = $clog2(RST_MIN + 1);

  logic [CNT_W-1:0] run_cnt;
  logic             run_qual;
  logic             lr_now;
  logic             hit_swd;
  logic             hit_jtag;
  port_mode_e       mode;

  ones_run_tracker #(
    .RST_MIN (RST_MIN),
    .CNT_W   (CNT_W)
  ) u_run (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .run_cnt  (run_cnt),
    .run_qual (run_qual),
    .lr_now   (lr_now),
    .lr_pulse (line_rst_pulse)
  );

  sel_code_matcher #(
    .ACCEPT_LEGACY (ACCEPT_LEGACY)
  ) u_match (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .run_qual (run_qual),
    .lr_now   (lr_now),
    .hit_swd  (hit_swd),
    .hit_jtag (hit_jtag)
  );

  port_mode_ctrl #(
    .TLR_ONES (TLR_ONES),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .run_cnt  (run_cnt),
    .hit_swd  (hit_swd),
    .hit_jtag (hit_jtag),
    .mode     (mode),
    .mode_chg (mode_chg_pulse),
    .tap_tlr  (tap_tlr)
  );

  assign mode_swd = (mode == PM_SWD);

  // R2: line reset and mode change never share a cycle
  p_lr_chg_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(line_rst_pulse && mode_chg_pulse));

endmodule

// File: tb/dbg_port_mode_detect_test.sv
`timescale 1ns/1ps
module dbg_port_mode_detect_test;

  localparam int RST_MIN = 51;
  localparam int CW      = 16;
  localparam int HW      = RST_MIN + CW;
  localparam logic [15:0] W_SWD  = 16'hE79E;
  localparam logic [15:0] W_JTAG = 16'hE73C;
  localparam logic [15:0] W_SWDO = 16'hEDB6;
  localparam logic [15:0] W_JTGO = 16'hDEAE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic mode_swd, line_rst_pulse, mode_chg_pulse, tap_tlr;

  int errors = 0;
  int checks = 0;
  string mode_tag = "R3";

  logic [HW-1:0] hist;
  logic e_mode, e_tlr, e_lr, e_chg;

  always #4 clk = ~clk;

  dbg_port_mode_detect uut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .mode_swd(mode_swd), .line_rst_pulse(line_rst_pulse),
    .mode_chg_pulse(mode_chg_pulse), .tap_tlr(tap_tlr)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] window_word(input logic [HW-1:0] h);
    logic [15:0] w;
    for (int i = 0; i < CW; i++) w[i] = h[CW-1-i];
    return w;
  endfunction

  task automatic model_step(input logic b);
    logic [15:0] w;
    logic pre, hs, hj;
    hist = {hist[HW-2:0], b};
    w    = window_word(hist);
    pre  = &hist[HW-1:CW];
    hs   = pre && (w == W_SWD  || w == W_SWDO);
    hj   = pre && (w == W_JTAG || w == W_JTGO);
    e_lr  = (&hist[RST_MIN-1:0]) && !hist[RST_MIN];
    e_chg = 1'b0;
    if (hs && !e_mode) begin e_mode = 1'b1; e_chg = 1'b1; end
    if (hj &&  e_mode) begin e_mode = 1'b0; e_chg = 1'b1; end
    if (hj)            e_tlr = 1'b1;
    else if (hs)       e_tlr = 1'b0;
    else if (!e_mode) begin
      if (!b)              e_tlr = 1'b0;
      else if (&hist[4:0]) e_tlr = 1'b1;
    end
  endtask

  task automatic model_reset();
    hist = '0; e_mode = 1'b0; e_tlr = 1'b1; e_lr = 1'b0; e_chg = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_vld = 1'b1; bit_in = b;
    model_step(b);
    @(negedge clk);
    bit_vld = 1'b0; bit_in = 1'($urandom);
    chk("R2", "line_rst_pulse", line_rst_pulse, e_lr);
    chk("R9", "mode_chg_pulse", mode_chg_pulse, e_chg);
    chk(mode_tag, "mode_swd", mode_swd, e_mode);
    chk("R10", "tap_tlr", tap_tlr, e_tlr);
    @(negedge clk);
    bit_in = 1'($urandom);
    chk("R11", "idle line_rst_pulse", line_rst_pulse, 1'b0);
    chk("R9", "idle mode_chg_pulse", mode_chg_pulse, 1'b0);
    chk("R11", "idle mode_swd", mode_swd, e_mode);
    chk("R11", "idle tap_tlr", tap_tlr, e_tlr);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 0; i < CW; i++) send_bit(w[i]);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [15:0] w;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "reset mode_swd", mode_swd, 1'b0);
    chk("R1", "reset tap_tlr", tap_tlr, 1'b1);
    chk("R1", "reset line_rst_pulse", line_rst_pulse, 1'b0);
    chk("R1", "reset mode_chg_pulse", mode_chg_pulse, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post-reset mode_swd", mode_swd, 1'b0);

    // R6: 50 ones is not enough
    mode_tag = "R6";
    send_bit(1'b0); send_ones(50); send_word(W_SWD);
    chk("R6", "short run ignored", mode_swd, 1'b0);

    // R3: current serial-wire word
    mode_tag = "R3";
    send_ones(51); send_word(W_SWD);
    chk("R3", "swd selected", mode_swd, 1'b1);

    // R8: same mode again
    mode_tag = "R8";
    send_ones(60); send_word(W_SWD);
    chk("R8", "swd kept", mode_swd, 1'b1);

    // R4: current JTAG word, then trailing ones hold TLR (R10)
    mode_tag = "R4";
    send_ones(55); send_word(W_JTAG);
    chk("R4", "jtag selected", mode_swd, 1'b0);
    chk("R10", "tlr after jtag select", tap_tlr, 1'b1);
    send_ones(5);
    chk("R10", "tlr held by ones", tap_tlr, 1'b1);
    send_bit(1'b0);
    chk("R10", "tlr cleared by low", tap_tlr, 1'b0);
    send_ones(5);
    chk("R10", "tlr set by five ones", tap_tlr, 1'b1);

    // R5: legacy words
    mode_tag = "R5";
    send_ones(52); send_word(W_SWDO);
    chk("R5", "legacy swd", mode_swd, 1'b1);
    send_ones(52); send_word(W_JTGO);
    chk("R5", "legacy jtag", mode_swd, 1'b0);

    // R7: mismatch then correct word without new line reset
    mode_tag = "R7";
    send_ones(53); send_word(W_SWD ^ 16'h0100); send_word(W_SWD);
    chk("R7", "discarded candidate", mode_swd, 1'b0);

    // random episodes, R3 family
    mode_tag = "R3";
    for (int ep = 0; ep < 120; ep++) begin
      int k;
      send_ones($urandom_range(44, 58));
      k = $urandom_range(0, 4);
      case (k)
        0: w = W_SWD;
        1: w = W_JTAG;
        2: w = W_SWDO;
        3: w = W_JTGO;
        default: w = W_JTAG ^ (16'h1 << $urandom_range(1, 15));
      endcase
      send_word(w);
      for (int t = 0, n = $urandom_range(0, 8); t < n; t++) send_bit(1'($urandom));
    end

    // R12: reset collides with last code bit
    @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    model_reset();
    send_bit(1'b0);
    send_ones(51);
    for (int i = 0; i < CW - 1; i++) send_bit(W_SWD[i]);
    @(negedge clk);
    rst = 1'b1; bit_vld = 1'b1; bit_in = W_SWD[CW-1];
    @(negedge clk);
    rst = 1'b0; bit_vld = 1'b0;
    model_reset();
    chk("R12", "reset wins mode", mode_swd, 1'b0);
    chk("R12", "reset wins pulse", mode_chg_pulse, 1'b0);
    @(negedge clk);
    chk("R12", "no late pulse", mode_chg_pulse, 1'b0);
    chk("R12", "mode still jtag", mode_swd, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule